// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one unsigned `WIDTH`-bit operand by another, producing one quotient bit per clock cycle with the restoring method. A partial-remainder register one bit wider than the operands sits beside a shift register that starts out holding the dividend. A third register holds the divisor for the whole operation. On every iteration the remainder and dividend registers move left together by one bit. The divisor is then tried against the partial remainder. If the trial difference is non-negative it is kept and a 1 enters the vacated low bit of the dividend register. If it is negative the previous value is restored and a 0 enters. After `WIDTH` iterations the dividend register holds the quotient and the low `WIDTH` bits of the partial remainder hold the remainder.

A caller pulses `start` with the operands on the ports while the unit is idle. It then waits for the one-cycle `done` pulse. Results stay on the outputs until the next operation is accepted. A zero divisor is flagged and still gives fully defined outputs. A parameter selects how the restore step is built: either by selecting the un-subtracted value, or by adding the divisor back onto the difference.

Top module: `seq_restoring_divider`

## Requirements
- R1: While and after reset, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are all zeros.
- R2: A `start` sampled high while `busy` is low accepts the operands. `busy` is high from the next cycle onward. `done` is high for exactly one cycle, `WIDTH` clock edges after the accepting edge. `busy` is low during that cycle.
- R3: For a nonzero divisor, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor, both unsigned; for example 274 / 13 gives 21 remainder 1. These values are valid in the cycle `done` is high.
- R4: A `start` sampled while `busy` is high is ignored: the running operation neither restarts nor changes its result, and `done` still comes `WIDTH` edges after the original accepting edge.
- R5: Changes on `dividend` and `divisor` after the accepting edge have no effect on the result.
- R6: With a zero divisor, `div_by_zero` is 1 together with `done`. `quotient` is all ones and `remainder` equals the dividend. The latency is the same as in R2.
- R7: After `done`, `quotient`, `remainder` and `div_by_zero` keep their values until the next operation is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; honoured only while idle |
| dividend | input | WIDTH | Unsigned dividend, sampled on the accepting edge |
| divisor | input | WIDTH | Unsigned divisor, sampled on the accepting edge |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| quotient | output | WIDTH | Unsigned quotient |
| remainder | output | WIDTH | Unsigned remainder |
| div_by_zero | output | 1 | The accepted divisor was zero |

## Verification
The bench builds the divider with `WIDTH` = 12 and the add-back restore variant. Twelve bits is wide enough for the 274 / 13 case and gives a latency short enough for several hundred random operations. The default elaboration covers the select variant at 8 bits. Directed cases cover a zero dividend, a zero divisor with zero and full-scale dividends, division by one, a full-scale divisor, and a divisor larger than the dividend. Further cases pulse `start` mid-operation and scramble the operand ports right after acceptance, so the capture and ignore rules are tested at the ports.

// File: rtl/divr_pkg.sv
package divr_pkg;

   typedef enum logic [0:0] {
      DIVR_IDLE = 1'b0,
      DIVR_RUN  = 1'b1
   } divr_state_e;

   // Restore-step implementation choices
   localparam int unsigned DIVR_RESTORE_SELECT  = 0;
   localparam int unsigned DIVR_RESTORE_ADDBACK = 1;

endpackage

// File: rtl/divr_sequencer.sv
module divr_sequencer
   import divr_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);

   localparam int unsigned CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

   divr_state_e      state_q;
   logic [CNT_W-1:0] iter_q;
   logic             done_q;
   logic             last_iter;

   assign busy      = (state_q == DIVR_RUN);
   assign load      = start && !busy;
   assign step      = busy;
   assign last_iter = (iter_q == LAST_CNT);
   assign done      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DIVR_IDLE;
         iter_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            DIVR_IDLE: begin
               if (load) begin
                  state_q <= DIVR_RUN;
                  iter_q  <= '0;
               end
            end
            DIVR_RUN: begin
               if (last_iter) begin
                  state_q <= DIVR_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  iter_q <= iter_q + 1'b1;
               end
            end
            default: state_q <= DIVR_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/divr_stage.sv
module divr_stage
   import divr_pkg::*;
#(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned RESTORE = DIVR_RESTORE_SELECT
) (
   input  logic [WIDTH:0]   part_in,
   input  logic             shift_bit,
   input  logic [WIDTH-1:0] dvsr,
   output logic [WIDTH:0]   part_out,
   output logic             qbit
);

   logic [WIDTH:0] shifted;
   logic [WIDTH:0] dvsr_ext;
   logic [WIDTH:0] trial;
   logic           negative;

   assign shifted  = {part_in[WIDTH-1:0], shift_bit};
   assign dvsr_ext = {1'b0, dvsr};
   assign trial    = shifted - dvsr_ext;
   // A set top bit before the shift means the shifted value exceeds any divisor
   assign negative = trial[WIDTH] && !part_in[WIDTH];
   assign qbit     = !negative;

   generate
      if (RESTORE == DIVR_RESTORE_ADDBACK) begin : g_addback
         logic [WIDTH:0] restored;
         assign restored = trial + dvsr_ext;
         assign part_out = negative ? restored : trial;
      end else begin : g_select
         assign part_out = negative ? shifted : trial;
      end
   endgenerate

endmodule

// File: rtl/divr_datapath.sv
module divr_datapath
   import divr_pkg::*;
#(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned RESTORE = DIVR_RESTORE_SELECT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic [WIDTH-1:0] quo,
   output logic [WIDTH-1:0] rem,
   output logic             zero_dvsr
);

   logic [WIDTH:0]   part_q;
   logic [WIDTH-1:0] shreg_q;
   logic [WIDTH-1:0] dvsr_q;
   logic             zero_q;
   logic [WIDTH:0]   part_nxt;
   logic             qbit;

   divr_stage #(
      .WIDTH   (WIDTH),
      .RESTORE (RESTORE)
   ) u_stage (
      .part_in   (part_q),
      .shift_bit (shreg_q[WIDTH-1]),
      .dvsr      (dvsr_q),
      .part_out  (part_nxt),
      .qbit      (qbit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q  <= '0;
         shreg_q <= '0;
         dvsr_q  <= '0;
         zero_q  <= 1'b0;
      end else if (load) begin
         part_q  <= '0;
         shreg_q <= dividend;
         dvsr_q  <= divisor;
         zero_q  <= (divisor == '0);
      end else if (step) begin
         part_q  <= part_nxt;
         shreg_q <= {shreg_q[WIDTH-2:0], qbit};
      end
   end

   assign quo       = shreg_q;
   assign rem       = part_q[WIDTH-1:0];
   assign zero_dvsr = zero_q;

endmodule

// File: rtl/seq_restoring_divider.sv
module seq_restoring_divider
   import divr_pkg::*;
#(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned RESTORE = DIVR_RESTORE_SELECT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder,
   output logic             div_by_zero
);

   initial begin
      assert (WIDTH >= 2) else $error("seq_restoring_divider: WIDTH must be at least 2");
      assert (RESTORE == DIVR_RESTORE_SELECT || RESTORE == DIVR_RESTORE_ADDBACK)
         else $error("seq_restoring_divider: unknown RESTORE variant");
   end

   logic load;
   logic step;

   divr_sequencer #(
      .WIDTH (WIDTH)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   divr_datapath #(
      .WIDTH   (WIDTH),
      .RESTORE (RESTORE)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .step      (step),
      .dividend  (dividend),
      .divisor   (divisor),
      .quo       (quotient),
      .rem       (remainder),
      .zero_dvsr (div_by_zero)
   );

endmodule

// File: rtl/seq_restoring_divider_chk.sv
module seq_restoring_divider_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [WIDTH-1:0] dividend,
   input logic [WIDTH-1:0] divisor,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] quotient,
   input logic [WIDTH-1:0] remainder,
   input logic             div_by_zero
);

   logic [31:0]        run_cnt;
   logic [WIDTH-1:0]   cap_a;
   logic [WIDTH-1:0]   cap_b;
   logic [2*WIDTH-1:0] recon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         cap_a   <= '0;
         cap_b   <= '0;
      end else if (start && !busy) begin
         run_cnt <= '0;
         cap_a   <= dividend;
         cap_b   <= divisor;
      end else if (busy) begin
         run_cnt <= run_cnt + 1;
      end
   end

   assign recon = (2*WIDTH)'(quotient) * (2*WIDTH)'(cap_b) + (2*WIDTH)'(remainder);

   // R1: nothing runs or reports straight out of reset
   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!busy && !done && !div_by_zero);
      end
   end

   // R2: done is a single-cycle pulse, never during busy
   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R2 / R4: done arrives WIDTH edges after acceptance, restarts ignored
   assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt == WIDTH));

   // R3: quotient and remainder reconstruct the captured dividend
   assert_div_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cap_b != '0) |-> (recon == (2*WIDTH)'(cap_a) && remainder < cap_b));

   // R6: zero divisor gives all-ones quotient and dividend as remainder
   assert_zero_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cap_b == '0) |-> (div_by_zero && quotient == '1 && remainder == cap_a));

   // R7: results held while idle with no new request
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

endmodule

bind seq_restoring_divider seq_restoring_divider_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/seq_restoring_divider_bench.sv
module seq_restoring_divider_bench;

   localparam int W          = 12;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;
   logic         busy, done, div_by_zero;
   logic [W-1:0] quotient, remainder;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seq_restoring_divider #(
      .WIDTH   (W),
      .RESTORE (1)
   ) u_seq_restoring_divider (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .dividend    (dividend),
      .divisor     (divisor),
      .busy        (busy),
      .done        (done),
      .quotient    (quotient),
      .remainder   (remainder),
      .div_by_zero (div_by_zero)
   );

   function automatic logic [W-1:0] ref_quo(input logic [W-1:0] a, input logic [W-1:0] b);
      return (b == '0) ? '1 : a / b;
   endfunction

   function automatic logic [W-1:0] ref_rem(input logic [W-1:0] a, input logic [W-1:0] b);
      return (b == '0) ? a : a % b;
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // disturb: pulse start with other operands two cycles into the run
   task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
      int lat;
      logic [W-1:0] eq, er;
      eq = ref_quo(a, b);
      er = ref_rem(a, b);
      @(negedge clk);
      start = 1'b1; dividend = a; divisor = b;
      @(negedge clk);
      start = 1'b0;
      // R5: scramble operand ports after acceptance
      dividend = W'($urandom); divisor = W'($urandom);
      chk("R2 busy after accept", busy, 1);
      lat = 0;
      while (!done && lat < W + 8) begin
         start = (disturb && lat == 2);
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      chk("R2 latency", lat, W);
      chk("R2 busy low at done", busy, 0);
      chk(disturb ? "R4 quotient" : (b == 0 ? "R6 quotient" : "R3 quotient"), quotient, eq);
      chk(disturb ? "R4 remainder" : (b == 0 ? "R6 remainder" : "R3 remainder"), remainder, er);
      chk("R6 flag", div_by_zero, (b == 0));
      @(negedge clk);
      chk("R2 done one cycle", done, 0);
      repeat (2) @(negedge clk);
      chk("R7 quotient held", quotient, eq);
      chk("R7 remainder held", remainder, er);
      chk("R7 flag held", div_by_zero, (b == 0));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 flag", div_by_zero, 0);
      chk("R1 quotient", quotient, 0);
      chk("R1 remainder", remainder, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after release", busy, 0);

      // directed corners
      run_div(12'd274, 12'd13, 0);       // R3 classic case
      run_div(12'd0, 12'd5, 0);
      run_div(12'hFFF, 12'd1, 0);
      run_div(12'hFFF, 12'hFFF, 0);
      run_div(12'd5, 12'hFFF, 0);
      run_div(12'd1, 12'd2, 0);
      run_div(12'd0, 12'd0, 0);          // R6
      run_div(12'hFFF, 12'd0, 0);        // R6
      run_div(12'd1234, 12'd0, 0);       // R6
      run_div(12'd274, 12'd13, 1);       // R4 restart ignored
      run_div(12'hABC, 12'd7, 1);        // R4

      // constrained random
      for (int i = 0; i < 300; i++) begin
         logic [W-1:0] a, b;
         a = W'($urandom);
         case ($urandom_range(0, 3))
            0: b = W'($urandom_range(0, 15));
            1: b = W'($urandom_range(1, 255));
            default: b = W'($urandom);
         endcase
         run_div(a, b, ($urandom_range(0, 9) == 0));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule